// File: doc/BRIEF.md
# Serial Memory Read Sequencer

This block is the target side of a mode-0 serial read for a byte-wide memory. The serial clock, select and data-in pins are brought into the system clock domain through a short synchronizer and their edges are detected there. While select is low, the first eight serial bits form an instruction. If that instruction is the read code, sixteen address bits follow. After the last of them, bytes are streamed out most significant bit first. A new byte is fetched for every byte sent, and the address advances by one each time.

The memory side is a plain synchronous read port: a one-cycle read strobe with an address, and the data is returned on the following system clock. Instructions other than read are handed out as a one-cycle pulse with their code, so that a separate decoder can deal with them. The output is given as a data bit together with an enable. The pad driver turns the enable into high impedance. Correct operation needs each serial clock level to last at least four system clocks.

Top module: `spi_rd_seq`

## Requirements
- R1: After a synchronous reset, `spi_so_en`, `op_valid` and `mem_rd_en` are all low.
- R2: The instruction is taken from the first eight serial clock rising edges after select falls, most significant bit first. The code 0x03 is a read. Any other code is presented on `op_code` exactly as sent.
- R3: For a read, the next sixteen rising edges give the address, most significant bit first. Only the low MEM_AW bits (default 11) select the memory location, and the upper bits have no effect on the data returned.
- R4: `spi_so_en` stays low during every instruction and address bit.
- R5: On the falling edge that follows the 24th rising edge, the sequencer raises `spi_so_en` and drives bit 7 of the byte at the start address. Each later falling edge moves to the next lower bit, so the bit is valid when the host samples it on the next rising edge.
- R6: For as long as select stays low, each further byte comes from the previous address plus one, and the address wraps from 2^MEM_AW−1 to 0.
- R7: A non-read code produces exactly one single-cycle `op_valid` pulse, and `spi_so_en` stays low for the rest of that transaction.
- R8: Raising select at any point ends the transaction. `spi_so_en` is low within SYNC_STAGES+2 system clocks, and the next select-low period starts again at the instruction.
- R9: Serial clock edges seen while select is high cause no memory read, no `op_valid` and no output enable.
- R10: `mem_rd_en` is a single-cycle strobe. A read of N full bytes issues exactly N+2 strobes: one when the address is complete, and one as each byte starts, including the byte that begins on the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idle low (mode 0) |
| spi_csn | input | 1 | Select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_en | output | 1 | Output enable for the data-out pad |
| op_valid | output | 1 | One-cycle pulse: a non-read instruction was received |
| op_code | output | OPC_W | Code of that instruction |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | MEM_AW | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, one clock after the strobe |

## Verification
Reads are started at a low address, just below the top of the array, and with the unused address bits set. These separate plain bit ordering from the wrap and from address masking. Non-read codes are sent, including the bit-reversed read code, to show that the instruction is taken most significant bit first and never starts a data phase. Select is cut in the middle of the address and in the middle of a byte, and clock edges are sent with select high. A following normal read then shows that no state survives into the next transaction.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  // transaction phase while select is low
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  localparam logic [7:0] RD_CODE_DEFAULT = 8'h03;

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csn,
  input  logic si,
  output logic csn_s,
  output logic si_s,
  output logic sck_rise,
  output logic sck_fall
);

  localparam int LAST = STAGES - 1;

  // each stage holds {csn, sck, si}
  logic [STAGES-1:0][2:0] stg_q;
  logic                   sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= 3'b100;
      sck_d <= 1'b0;
    end else begin
      stg_q[0] <= {csn, sck, si};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sck_d <= stg_q[LAST][1];
    end
  end

  assign csn_s    = stg_q[LAST][2];
  assign si_s     = stg_q[LAST][0];
  assign sck_rise =  stg_q[LAST][1] & ~sck_d;
  assign sck_fall = ~stg_q[LAST][1] &  sck_d;

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int         OPC_W   = 8,
  parameter int         ADR_W   = 16,
  parameter int         MEM_AW  = 11,
  parameter int         DATA_W  = 8,
  parameter logic [7:0] READ_OP = RD_CODE_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              si_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  output logic              op_valid,
  output logic [OPC_W-1:0]  op_code,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              tx_load,
  output logic              tx_shift
);

  localparam int SH_W  = (ADR_W > OPC_W) ? ADR_W : OPC_W;
  localparam int CNT_W = $clog2(SH_W) + 1;
  localparam int BIT_W = $clog2(DATA_W);

  phase_e            ph_q;
  logic [CNT_W-1:0]  rcnt_q;
  logic [SH_W-1:0]   sh_q;
  logic [BIT_W-1:0]  fcnt_q;
  logic [SH_W-1:0]   sh_nx;
  logic              in_data;

  assign sh_nx   = {sh_q[SH_W-2:0], si_s};
  assign in_data = (ph_q == PH_DATA);
  assign tx_load  = sck_fall & in_data & (fcnt_q == '0);
  assign tx_shift = sck_fall & in_data & (fcnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_CMD;
      rcnt_q    <= '0;
      sh_q      <= '0;
      fcnt_q    <= '0;
      op_valid  <= 1'b0;
      op_code   <= '0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
    end else if (csn_s) begin
      ph_q      <= PH_CMD;
      rcnt_q    <= '0;
      fcnt_q    <= '0;
      op_valid  <= 1'b0;
      mem_rd_en <= 1'b0;
    end else begin
      op_valid  <= 1'b0;
      mem_rd_en <= 1'b0;
      if (sck_rise) begin
        unique case (ph_q)
          PH_CMD: begin
            sh_q   <= sh_nx;
            rcnt_q <= rcnt_q + 1'b1;
            if (rcnt_q == CNT_W'(OPC_W - 1)) begin
              rcnt_q <= '0;
              if (sh_nx[OPC_W-1:0] == READ_OP[OPC_W-1:0]) begin
                ph_q <= PH_ADDR;
              end else begin
                ph_q     <= PH_SKIP;
                op_valid <= 1'b1;
                op_code  <= sh_nx[OPC_W-1:0];
              end
            end
          end
          PH_ADDR: begin
            sh_q   <= sh_nx;
            rcnt_q <= rcnt_q + 1'b1;
            if (rcnt_q == CNT_W'(ADR_W - 1)) begin
              rcnt_q    <= '0;
              ph_q      <= PH_DATA;
              mem_addr  <= sh_nx[MEM_AW-1:0];
              mem_rd_en <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && in_data) begin
        fcnt_q <= fcnt_q + 1'b1;
        if (fcnt_q == '0) begin
          // the held byte goes out now; fetch the one after it
          mem_addr  <= mem_addr + 1'b1;
          mem_rd_en <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              load,
  input  logic              shift,
  output logic              so,
  output logic              so_en
);

  logic              rd_pend_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      hold_q    <= '0;
      sh_q      <= '0;
      so_en     <= 1'b0;
    end else begin
      rd_pend_q <= mem_rd_en;
      if (rd_pend_q) hold_q <= mem_rdata;
      if (load)       sh_q <= hold_q;
      else if (shift) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      if (csn_s)     so_en <= 1'b0;
      else if (load) so_en <= 1'b1;
    end
  end

  assign so = sh_q[DATA_W-1];

endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq
  import spi_rd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         OPC_W       = 8,
  parameter int         ADR_W       = 16,
  parameter int         MEM_AW      = 11,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] READ_OP     = RD_CODE_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_en,
  output logic              op_valid,
  output logic [OPC_W-1:0]  op_code,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic csn_s, si_s, sck_rise, sck_fall;
  logic tx_load, tx_shift;

  spi_rd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .sck      (spi_sck),
    .csn      (spi_csn),
    .si       (spi_si),
    .csn_s    (csn_s),
    .si_s     (si_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  spi_rd_ctrl #(
    .OPC_W   (OPC_W),
    .ADR_W   (ADR_W),
    .MEM_AW  (MEM_AW),
    .DATA_W  (DATA_W),
    .READ_OP (READ_OP)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .csn_s     (csn_s),
    .si_s      (si_s),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .tx_load   (tx_load),
    .tx_shift  (tx_shift)
  );

  spi_rd_tx #(.DATA_W(DATA_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .csn_s     (csn_s),
    .mem_rd_en (mem_rd_en),
    .mem_rdata (mem_rdata),
    .load      (tx_load),
    .shift     (tx_shift),
    .so        (spi_so),
    .so_en     (spi_so_en)
  );

endmodule

// File: rtl/spi_rd_seq_chk.sv
module spi_rd_seq_chk #(
  parameter int         SYNC_STAGES = 2,
  parameter int         OPC_W       = 8,
  parameter int         MEM_AW      = 11,
  parameter logic [7:0] READ_OP     = 8'h03
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_csn,
  input logic              spi_so_en,
  input logic              op_valid,
  input logic [OPC_W-1:0]  op_code,
  input logic              mem_rd_en,
  input logic [MEM_AW-1:0] mem_addr
);

  localparam int HI_LIM = SYNC_STAGES + 2;

  logic [7:0]        hi_cnt;
  logic [MEM_AW-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      prev_addr <= '0;
    end else begin
      if (!spi_csn)                 hi_cnt <= '0;
      else if (hi_cnt < 8'(HI_LIM)) hi_cnt <= hi_cnt + 1'b1;
      if (mem_rd_en) prev_addr <= mem_addr;
    end
  end

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt >= 8'(HI_LIM)) |-> !spi_so_en);

  // R7
  op_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);

  // R7
  op_not_read_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_code != READ_OP[OPC_W-1:0]));

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && spi_so_en) |-> (mem_addr == prev_addr + 1'b1));

endmodule

bind spi_rd_seq spi_rd_seq_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .OPC_W       (OPC_W),
  .MEM_AW      (MEM_AW),
  .READ_OP     (READ_OP)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .spi_csn   (spi_csn),
  .spi_so_en (spi_so_en),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr)
);

// File: tb/spi_rd_seq_tb_top.sv
module spi_rd_seq_tb_top;

  localparam int SYNC   = 2;
  localparam int MEM_AW = 11;
  localparam int MASK   = (1 << MEM_AW) - 1;
  localparam int H      = 6;   // system clocks per serial clock level

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              spi_sck = 1'b0;
  logic              spi_csn = 1'b1;
  logic              spi_si = 1'b0;
  logic              spi_so, spi_so_en, op_valid, mem_rd_en;
  logic [7:0]        op_code;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_rdata = 8'h00;

  int n_cmp = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int op_cnt = 0;
  logic [7:0] op_last = 8'h00;

  always #2 clk = ~clk;

  spi_rd_seq dut_i (
    .clk       (clk),
    .rst       (rst),
    .spi_sck   (spi_sck),
    .spi_csn   (spi_csn),
    .spi_si    (spi_si),
    .spi_so    (spi_so),
    .spi_so_en (spi_so_en),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] mem_f(input int a);
    return 8'((a * 37) ^ (a >> 3) ^ 8'h5A);
  endfunction

  // memory model: one-cycle synchronous read
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_f(int'(mem_addr));

  always @(negedge clk) begin
    if (mem_rd_en) rd_cnt++;
    if (op_valid) begin
      op_cnt++;
      op_last = op_code;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic b, output logic s, output logic e);
    spi_si = b;
    repeat (H) @(negedge clk);
    s = spi_so;
    e = spi_so_en;
    spi_sck = 1'b1;
    repeat (H) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic txn(input logic [7:0] op, input logic [15:0] adr,
                     input int hdr_bits, input int nbits, input string tag0);
    logic s, e;
    int rd0, op0, a;
    logic [7:0] exp;
    logic [23:0] hdr;
    bit is_rd;
    hdr   = {op, adr};
    is_rd = (op == 8'h03);
    rd0   = rd_cnt;
    op0   = op_cnt;
    spi_csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < hdr_bits; i++) begin
      xfer(hdr[23-i], s, e);
      chk(e == 1'b0, (i >= 8 && !is_rd) ? "R7" : "R4", e, 0);
    end
    if (hdr_bits == 24) begin
      for (int j = 0; j < nbits; j++) begin
        xfer(1'b0, s, e);
        if (is_rd) begin
          a   = (int'(adr) + j / 8) & MASK;
          exp = mem_f(a);
          chk(e == 1'b1, "R5", e, 1);
          chk(s == exp[7 - (j % 8)], (j < 8) ? tag0 : "R6", s, exp[7 - (j % 8)]);
        end else begin
          chk(e == 1'b0, "R7", e, 0);
        end
      end
    end
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    chk(spi_so_en == 1'b0, "R8", spi_so_en, 0);
    // R10: strobes = 2 + full bytes for a completed read header
    chk(rd_cnt - rd0 == ((is_rd && hdr_bits == 24) ? 2 + nbits / 8 : 0), "R10",
        rd_cnt - rd0, (is_rd && hdr_bits == 24) ? 2 + nbits / 8 : 0);
    chk(op_cnt - op0 == ((!is_rd && hdr_bits >= 8) ? 1 : 0), "R7",
        op_cnt - op0, (!is_rd && hdr_bits >= 8) ? 1 : 0);
    if (!is_rd && hdr_bits >= 8) chk(op_last == op, "R2", op_last, op);
    repeat (H) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    int rd0, op0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1
    chk(spi_so_en == 1'b0, "R1", spi_so_en, 0);
    chk(op_valid == 1'b0, "R1", op_valid, 0);
    chk(mem_rd_en == 1'b0, "R1", mem_rd_en, 0);

    // R5 plain read, several bytes
    txn(8'h03, 16'h0010, 24, 32, "R5");
    // R6 wrap at top of the array
    txn(8'h03, 16'h07FE, 24, 32, "R6");
    // R3 upper address bits ignored: 0xF805 reads location 0x005
    txn(8'h03, 16'hF805, 24, 16, "R3");
    // R7 other code, R2 bit order (0xC0 is the reversed read code)
    txn(8'h06, 16'h0000, 24, 16, "R7");
    txn(8'hC0, 16'h0003, 24, 8, "R2");
    // R8 abort inside the address, then a fresh read
    txn(8'h03, 16'h0123, 14, 0, "R8");
    txn(8'h03, 16'h0123, 24, 16, "R8");
    // R8 abort in the middle of a byte
    txn(8'h03, 16'h0040, 24, 12, "R8");

    // R9 clock edges with select high
    rd0 = rd_cnt;
    op0 = op_cnt;
    for (int k = 0; k < 30; k++) begin
      spi_si  = k[0];
      spi_sck = 1'b1;
      repeat (H) @(negedge clk);
      spi_sck = 1'b0;
      repeat (H) @(negedge clk);
      chk(spi_so_en == 1'b0, "R9", spi_so_en, 0);
    end
    chk(rd_cnt == rd0, "R9", rd_cnt - rd0, 0);
    chk(op_cnt == op0, "R9", op_cnt - op0, 0);
    txn(8'h03, 16'h03A7, 24, 24, "R9");

    finish_run();
  end

endmodule